// File: doc/BRIEF.md
# Priority-Based Clock Reference Selector

This block decides which of several clock references drives a timing generator, or whether the generator should coast in holdover or run free. Each reference comes with a qualification flag and a programmable priority. A mode input picks one of three ways to choose. Automatic election takes the best qualified reference. Manual selection takes a code written by software. Hard-wired selection uses a switch pin to choose between two preset codes.

The result is held in a register. It is presented as a reference index, a timing-generator state and a one-cycle change strobe. When no reference can be used, the block falls back to holdover if holdover history is valid, and to freerun if it is not. In automatic mode, a revertive setting decides whether a better reference may displace a current one that is still good.

Top module: `ref_selector`

## Requirements
- R1: While `rst` is high, at every clock edge the outputs are set to freerun (`tg_state`=0), `sel_ref`=0 and `sel_change`=0.
- R2: In automatic mode, the eligible qualified reference with the numerically smallest priority is chosen. When two references share a priority, the lower index wins. Priority of reference i is `ref_prio[i*PRIO_W +: PRIO_W]`.
- R3: A reference whose priority is 0 never wins automatic election, even if it is qualified.
- R4: In automatic mode with `revert_en`=1, an eligible reference with a strictly smaller priority number displaces the current one. An equal priority does not.
- R5: In automatic mode with `revert_en`=0, the current reference is kept while it stays qualified with a nonzero priority. A new election happens only when it loses eligibility.
- R6: When no choice yields a reference, the state is holdover (`tg_state`=1) if `hold_valid` is high and freerun (`tg_state`=0) otherwise. Holdover turns into freerun once `hold_valid` is sampled low. In both of these states `sel_ref`=0.
- R7: In manual mode, `man_code` values below N select that reference (`tg_state`=2), even if it is unqualified. Value N requests holdover. Any larger value requests freerun. Qualification flags and automatic election have no effect.
- R8: In hard-wired mode, `hw_switch`=0 selects `hw_code_a` and `hw_switch`=1 selects `hw_code_b`. Both use the same code meaning as R7. Qualification flags have no effect.
- R9: Every output change takes effect one clock after the inputs that cause it. `sel_change` is high for exactly the cycle in which `tg_state` or `sel_ref` differs from its previous value.
- R10: `sel_mode` encoding: 0 automatic, 1 manual, 2 hard-wired, 3 automatic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_ok | input | N | Per-reference qualified flag |
| ref_prio | input | N*PRIO_W | Packed per-reference priorities, 0 = excluded |
| revert_en | input | 1 | Revertive election enable |
| sel_mode | input | 2 | Selection mode |
| man_code | input | IDX_W | Manual choice code |
| hw_code_a | input | IDX_W | Preset code used when switch is low |
| hw_code_b | input | IDX_W | Preset code used when switch is high |
| hw_switch | input | 1 | Hard-wired selection pin |
| hold_valid | input | 1 | Holdover history available |
| sel_ref | output | IDX_W | Selected reference index |
| tg_state | output | 2 | 0 freerun, 1 holdover, 2 synchronized |
| sel_change | output | 1 | One-cycle strobe on selection change |

## Verification
The bench uses the default parameters: five references, 4-bit priorities, and 3-bit codes derived from those. With a 3-bit code the manual and hard-wired inputs can express every reference, the holdover code 5 and the freerun codes 6 and 7. This lets the bench check that only code N means holdover. The 4-bit priorities leave room to set up ties, the priority-0 exclusion, and strict versus equal preemption in revertive mode.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

    typedef enum logic [1:0] {
        ST_FREERUN  = 2'd0,
        ST_HOLDOVER = 2'd1,
        ST_SYNC     = 2'd2
    } tg_state_e;

    typedef enum logic [1:0] {
        MD_AUTO      = 2'd0,
        MD_MANUAL    = 2'd1,
        MD_HARDWIRED = 2'd2,
        MD_AUTO_ALT  = 2'd3
    } sel_mode_e;

    function automatic tg_state_e fallback_state(input logic hist_ok);
        return hist_ok ? ST_HOLDOVER : ST_FREERUN;
    endfunction

endpackage

// File: rtl/refsel_elect.sv
module refsel_elect
    import refsel_pkg::*;
#(
    parameter int N      = 5,
    parameter int PRIO_W = 4,
    parameter int IDX_W  = 3
) (
    input  logic [N-1:0]        ok,
    input  logic [N*PRIO_W-1:0] prio_flat,
    output logic                found,
    output logic [IDX_W-1:0]    best_idx,
    output logic [PRIO_W-1:0]   best_prio
);
    logic [PRIO_W-1:0] prio_a [N];
    logic [N-1:0]      elig;

    for (genvar g = 0; g < N; g++) begin : g_ref
        assign prio_a[g] = prio_flat[g*PRIO_W +: PRIO_W];
        assign elig[g]   = ok[g] && (prio_a[g] != '0);
    end

    // Sequential scan: strict compare keeps the lowest index on ties.
    always_comb begin
        found     = 1'b0;
        best_idx  = '0;
        best_prio = '1;
        for (int i = 0; i < N; i++) begin
            if (elig[i] && (!found || prio_a[i] < best_prio)) begin
                found     = 1'b1;
                best_idx  = IDX_W'(i);
                best_prio = prio_a[i];
            end
        end
    end
endmodule

// File: rtl/refsel_auto.sv
module refsel_auto
    import refsel_pkg::*;
#(
    parameter int N      = 5,
    parameter int PRIO_W = 4,
    parameter int IDX_W  = 3
) (
    input  tg_state_e           cur_st,
    input  logic [IDX_W-1:0]    cur_idx,
    input  logic [N-1:0]        ok,
    input  logic [N*PRIO_W-1:0] prio_flat,
    input  logic                revert_en,
    input  logic                hold_valid,
    input  logic                found,
    input  logic [IDX_W-1:0]    best_idx,
    input  logic [PRIO_W-1:0]   best_prio,
    output tg_state_e           nxt_st,
    output logic [IDX_W-1:0]    nxt_idx
);
    logic              cur_ok;
    logic [PRIO_W-1:0] cur_prio;
    logic              cur_keep;

    always_comb begin
        cur_ok   = 1'b0;
        cur_prio = '0;
        for (int i = 0; i < N; i++) begin
            if (IDX_W'(i) == cur_idx) begin
                cur_ok   = ok[i];
                cur_prio = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
        cur_keep = (cur_st == ST_SYNC) && cur_ok && (cur_prio != '0);
    end

    always_comb begin
        if (cur_keep) begin
            if (revert_en && found && (best_prio < cur_prio)) begin
                nxt_st  = ST_SYNC;
                nxt_idx = best_idx;
            end else begin
                nxt_st  = ST_SYNC;
                nxt_idx = cur_idx;
            end
        end else if (found) begin
            nxt_st  = ST_SYNC;
            nxt_idx = best_idx;
        end else begin
            nxt_st  = fallback_state(hold_valid);
            nxt_idx = '0;
        end
    end
endmodule

// File: rtl/refsel_decode.sv
module refsel_decode
    import refsel_pkg::*;
#(
    parameter int N     = 5,
    parameter int IDX_W = 3
) (
    input  logic [IDX_W-1:0] code,
    input  logic             hold_valid,
    output tg_state_e        st,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] HOLD_CODE = IDX_W'(N);

    always_comb begin
        if (code < HOLD_CODE) begin
            st  = ST_SYNC;
            idx = code;
        end else if (code == HOLD_CODE) begin
            st  = fallback_state(hold_valid);
            idx = '0;
        end else begin
            st  = ST_FREERUN;
            idx = '0;
        end
    end
endmodule

// File: rtl/ref_selector.sv
module ref_selector
    import refsel_pkg::*;
#(
    parameter int N      = 5,
    parameter int PRIO_W = 4,
    parameter int IDX_W  = $clog2(N + 2)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N-1:0]        ref_ok,
    input  logic [N*PRIO_W-1:0] ref_prio,
    input  logic                revert_en,
    input  logic [1:0]          sel_mode,
    input  logic [IDX_W-1:0]    man_code,
    input  logic [IDX_W-1:0]    hw_code_a,
    input  logic [IDX_W-1:0]    hw_code_b,
    input  logic                hw_switch,
    input  logic                hold_valid,
    output logic [IDX_W-1:0]    sel_ref,
    output logic [1:0]          tg_state,
    output logic                sel_change
);
    typedef struct packed {
        tg_state_e        st;
        logic [IDX_W-1:0] idx;
    } sel_t;

    sel_t sel_q, sel_d, auto_sel, man_sel, hw_sel;
    logic              strobe_q;
    logic              e_found;
    logic [IDX_W-1:0]  e_idx;
    logic [PRIO_W-1:0] e_prio;
    logic [IDX_W-1:0]  hw_code;

    refsel_elect #(.N(N), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_elect (
        .ok        (ref_ok),
        .prio_flat (ref_prio),
        .found     (e_found),
        .best_idx  (e_idx),
        .best_prio (e_prio)
    );

    refsel_auto #(.N(N), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_auto (
        .cur_st     (sel_q.st),
        .cur_idx    (sel_q.idx),
        .ok         (ref_ok),
        .prio_flat  (ref_prio),
        .revert_en  (revert_en),
        .hold_valid (hold_valid),
        .found      (e_found),
        .best_idx   (e_idx),
        .best_prio  (e_prio),
        .nxt_st     (auto_sel.st),
        .nxt_idx    (auto_sel.idx)
    );

    refsel_decode #(.N(N), .IDX_W(IDX_W)) u_man_dec (
        .code       (man_code),
        .hold_valid (hold_valid),
        .st         (man_sel.st),
        .idx        (man_sel.idx)
    );

    assign hw_code = hw_switch ? hw_code_b : hw_code_a;

    refsel_decode #(.N(N), .IDX_W(IDX_W)) u_hw_dec (
        .code       (hw_code),
        .hold_valid (hold_valid),
        .st         (hw_sel.st),
        .idx        (hw_sel.idx)
    );

    always_comb begin
        unique case (sel_mode_e'(sel_mode))
            MD_MANUAL:    sel_d = man_sel;
            MD_HARDWIRED: sel_d = hw_sel;
            default:      sel_d = auto_sel;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q    <= '{st: ST_FREERUN, idx: '0};
            strobe_q <= 1'b0;
        end else begin
            sel_q    <= sel_d;
            strobe_q <= (sel_d != sel_q);
        end
    end

    assign sel_ref    = sel_q.idx;
    assign tg_state   = sel_q.st;
    assign sel_change = strobe_q;
endmodule

// File: rtl/refsel_chk.sv
module refsel_chk
    import refsel_pkg::*;
#(
    parameter int N      = 5,
    parameter int PRIO_W = 4,
    parameter int IDX_W  = $clog2(N + 2)
) (
    input logic                clk,
    input logic                rst,
    input logic [N-1:0]        ref_ok,
    input logic [N*PRIO_W-1:0] ref_prio,
    input logic                revert_en,
    input logic [1:0]          sel_mode,
    input logic [IDX_W-1:0]    man_code,
    input logic [IDX_W-1:0]    hw_code_a,
    input logic [IDX_W-1:0]    hw_code_b,
    input logic                hw_switch,
    input logic                hold_valid,
    input logic [IDX_W-1:0]    sel_ref,
    input logic [1:0]          tg_state,
    input logic                sel_change
);
    localparam logic [IDX_W-1:0] NCODE = IDX_W'(N);

    logic cur_good;
    logic is_auto;

    always_comb begin
        cur_good = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (IDX_W'(i) == sel_ref)
                cur_good = ref_ok[i] && (ref_prio[i*PRIO_W +: PRIO_W] != '0);
        end
        is_auto = (sel_mode == MD_AUTO) || (sel_mode == MD_AUTO_ALT);
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (tg_state == ST_FREERUN && sel_ref == '0 && !sel_change));

    // R9
    strobe_match_chk: assert property (@(posedge clk) disable iff (rst)
        sel_change == ((tg_state != $past(tg_state)) || (sel_ref != $past(sel_ref))));

    // R6
    holdover_hist_chk: assert property (@(posedge clk) disable iff (rst)
        (tg_state == ST_HOLDOVER) |-> $past(hold_valid));

    // R6
    noqual_nosync_chk: assert property (@(posedge clk) disable iff (rst)
        (is_auto && ref_ok == '0) |=> (tg_state != ST_SYNC));

    // R5
    nonrevert_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (is_auto && !revert_en && tg_state == ST_SYNC && cur_good)
        |=> (tg_state == ST_SYNC && sel_ref == $past(sel_ref)));

    // R7
    manual_ref_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_mode == MD_MANUAL && man_code < NCODE)
        |=> (tg_state == ST_SYNC && sel_ref == $past(man_code)));

    // R8
    hw_low_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_mode == MD_HARDWIRED && !hw_switch && hw_code_a < NCODE)
        |=> (tg_state == ST_SYNC && sel_ref == $past(hw_code_a)));

    // R8
    hw_high_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_mode == MD_HARDWIRED && hw_switch && hw_code_b < NCODE)
        |=> (tg_state == ST_SYNC && sel_ref == $past(hw_code_b)));
endmodule

bind ref_selector refsel_chk #(.N(N), .PRIO_W(PRIO_W)) u_refsel_chk (.*);

// File: tb/tb_ref_selector.sv
`timescale 1ns/1ps
module tb_ref_selector;
    import refsel_pkg::*;

    localparam int N      = 5;
    localparam int PRIO_W = 4;
    localparam int IDX_W  = 3;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [N-1:0]        ref_ok = '0;
    logic [N*PRIO_W-1:0] ref_prio = '0;
    logic                revert_en = 1'b0;
    logic [1:0]          sel_mode = 2'd0;
    logic [IDX_W-1:0]    man_code = '0;
    logic [IDX_W-1:0]    hw_code_a = '0;
    logic [IDX_W-1:0]    hw_code_b = '0;
    logic                hw_switch = 1'b0;
    logic                hold_valid = 1'b0;
    logic [IDX_W-1:0]    sel_ref;
    logic [1:0]          tg_state;
    logic                sel_change;

    always #2 clk = ~clk;

    ref_selector #(.N(N), .PRIO_W(PRIO_W)) dut (.*);

    typedef struct {
        int    st;
        int    idx;
        int    strobe;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   errors = 0;
    int   checks = 0;
    int   prev_st = 0;
    int   prev_idx = 0;
    bit   done = 1'b0;

    task automatic check(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic set_prio(input int i, input int v);
        ref_prio[i*PRIO_W +: PRIO_W] = PRIO_W'(v);
    endtask

    // Driver side: queue expectation, strobe derived from the previous expectation (R9)
    task automatic push_exp(input int st, input int idx, input string tag);
        exp_t e;
        e.st     = st;
        e.idx    = idx;
        e.strobe = (st != prev_st || idx != prev_idx) ? 1 : 0;
        e.tag    = tag;
        prev_st  = st;
        prev_idx = idx;
        exp_q.push_back(e);
    endtask

    // Monitor: outputs register one edge after inputs are driven at the negedge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check({e.tag, " state"}, int'(tg_state), e.st);
                check({e.tag, " ref"}, int'(sel_ref), e.idx);
                check({e.tag, " R9 strobe"}, int'(sel_change), e.strobe);
            end
        end
    end

    initial begin
        #100000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        set_prio(0, 3); set_prio(1, 2); set_prio(2, 2); set_prio(3, 0); set_prio(4, 5);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 state", int'(tg_state), 0);
        check("R1 ref", int'(sel_ref), 0);
        check("R1 strobe", int'(sel_change), 0);
        rst = 1'b0;

        @(negedge clk); sel_mode = 2'd0; ref_ok = '0; hold_valid = 0;
        push_exp(ST_FREERUN, 0, "R6 no ref no history");
        @(negedge clk); ref_ok = 5'b11111;
        push_exp(ST_SYNC, 1, "R2 R3 tie and zero priority");
        @(negedge clk); revert_en = 1; set_prio(2, 1);
        push_exp(ST_SYNC, 2, "R4 revertive preempt");
        @(negedge clk); set_prio(0, 1);
        push_exp(ST_SYNC, 2, "R4 equal priority kept");
        @(negedge clk); revert_en = 0; ref_ok = 5'b11011;
        push_exp(ST_SYNC, 0, "R5 switch on loss");
        @(negedge clk); set_prio(0, 4); ref_ok = 5'b11111;
        push_exp(ST_SYNC, 0, "R5 non-revertive keep");
        @(negedge clk); ref_ok = 5'b01000; hold_valid = 1;
        push_exp(ST_HOLDOVER, 0, "R3 R6 holdover");
        @(negedge clk); hold_valid = 0;
        push_exp(ST_FREERUN, 0, "R6 history lost");
        @(negedge clk); hold_valid = 1; ref_ok = '0;
        push_exp(ST_HOLDOVER, 0, "R6 history back");
        @(negedge clk); sel_mode = 2'd1; man_code = 3'd3;
        push_exp(ST_SYNC, 3, "R7 manual unqualified ref");
        @(negedge clk); ref_ok = 5'b11111;
        push_exp(ST_SYNC, 3, "R7 auto ignored");
        @(negedge clk); man_code = 3'd5;
        push_exp(ST_HOLDOVER, 0, "R7 manual holdover");
        @(negedge clk); hold_valid = 0;
        push_exp(ST_FREERUN, 0, "R6 manual holdover no history");
        @(negedge clk); hold_valid = 1; man_code = 3'd7;
        push_exp(ST_FREERUN, 0, "R7 code above holdover");
        @(negedge clk); sel_mode = 2'd2; hw_code_a = 3'd4; hw_code_b = 3'd1; hw_switch = 0;
        push_exp(ST_SYNC, 4, "R8 switch low");
        @(negedge clk); hw_switch = 1;
        push_exp(ST_SYNC, 1, "R8 switch high");
        @(negedge clk); ref_ok = '0;
        push_exp(ST_SYNC, 1, "R8 qualification ignored");
        @(negedge clk); hw_code_b = 3'd6;
        push_exp(ST_FREERUN, 0, "R8 freerun code");
        @(negedge clk); sel_mode = 2'd3; ref_ok = 5'b11111; revert_en = 1;
        push_exp(ST_SYNC, 2, "R10 mode 3 is automatic");
        @(negedge clk); sel_mode = 2'd0; ref_ok = 5'b10000;
        push_exp(ST_SYNC, 4, "R2 only remaining");
        @(negedge clk); ref_ok = 5'b10100;
        push_exp(ST_SYNC, 2, "R4 revert to better");
        @(negedge clk); revert_en = 0; ref_ok = 5'b10110; set_prio(1, 1);
        push_exp(ST_SYNC, 2, "R5 keep despite tie");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule